// File: doc/BRIEF.md
# Dual-Mode Synchronous Serial Port

This block is one channel of a byte-wide synchronous serial port. Each transfer moves exactly eight bits. It can run with separate clock, data-out and data-in wires, or with a clock and a single shared data wire whose direction is chosen per transfer. A control bit selects whether bits travel most significant first or least significant first, and that choice applies to both the transmitted and the received byte.

As master, the channel makes its own serial clock by dividing the system clock by one of six fixed ratios. As slave, it follows a clock that arrives from outside. Output data changes on the falling clock edge and input data is sampled on the rising edge. The clock idles high.

Software first loads the byte to send and then pulses the start strobe. The channel shows busy until the eighth rising edge. At that edge it hands back the received byte and raises an interrupt request, which stays set until software clears it. A system normally places two identical channels side by side.

Top module: `ssp_port`

## Requirements
- R1: A transfer shifts exactly 8 bits in both directions. With both ends set to the same bit order, each end's read data afterwards equals the byte the other end loaded.
- R2: When `cfg_lsb_first_i` is 1, bit 0 is sent first and the first received bit lands in bit 0. When it is 0, bit 7 is sent first and the first received bit lands in bit 7. A transfer between ends of opposite order therefore delivers each byte bit-reversed.
- R3: As master, one serial clock period lasts N system clocks, where rate codes 0 to 5 give N = 360, 120, 24, 16, 12 and 10. Busy therefore stays high for exactly 8·N cycles.
- R4: Rate codes 6 and 7 behave exactly like code 0.
- R5: The serial clock output idles high. `sck_oe_o` follows `cfg_master_i`, so a slave never drives the clock.
- R6: In 2-wire mode (`cfg_two_wire_i`=1), `cfg_tx_dir_i` is captured at start. A value of 1 drives the shared line from `sd_o` with `sd_oe_o`=1. A value of 0 keeps `sd_oe_o`=0 for the whole transfer and samples `sd_i`. In 3-wire mode `sd_oe_o` is 1 and input comes from `si_i`.
- R7: Busy rises on the clock edge after a start strobe taken while idle. A data write while busy is ignored and changes neither the bits sent nor the byte received.
- R8: The interrupt request rises on the edge at which busy falls and stays high until `irq_clr_i` is pulsed.
- R9: As slave, the channel shifts on the edges of `sck_i` once it has been started, and it completes after eight rising edges of `sck_i`.
- R10: After reset, busy and the interrupt request are low and `sck_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_master_i | input | 1 | 1 = master (drives clock), 0 = slave |
| cfg_two_wire_i | input | 1 | 1 = shared data line, 0 = separate in/out |
| cfg_lsb_first_i | input | 1 | Bit order select |
| cfg_tx_dir_i | input | 1 | 2-wire direction: 1 transmit, 0 receive |
| cfg_rate_i | input | 3 | Master clock rate code |
| wr_en_i | input | 1 | Load transmit byte (ignored while busy) |
| wr_data_i | input | 8 | Transmit byte |
| start_i | input | 1 | Start strobe |
| irq_clr_i | input | 1 | Clear interrupt request |
| sck_i | input | 1 | External serial clock (slave) |
| si_i | input | 1 | Serial data in, 3-wire mode |
| sd_i | input | 1 | Shared data line input, 2-wire mode |
| sck_o | output | 1 | Serial clock out |
| sck_oe_o | output | 1 | Serial clock output enable |
| sd_o | output | 1 | Serial data out |
| sd_oe_o | output | 1 | Serial data output enable |
| rd_data_o | output | 8 | Received byte |
| busy_o | output | 1 | Transfer in progress |
| irq_o | output | 1 | Completion interrupt request |

## Verification
For a master with ratio N, busy is high for 8·N cycles counted from the edge after the start strobe. The bench counts those cycles at falling edges and compares the count with 8·N computed from the rate code. Read data and the interrupt request become valid on the same edge at which busy falls. A slave fed from a master finishes three cycles later, because of its clock synchronizer. The bench therefore waits for both channels to go idle before it compares either read-back byte, and it samples mid-transfer values such as the data output enable half-way through a busy window.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned RATE_W = 3;

  typedef struct packed {
    logic              master;
    logic              two_wire;
    logic              lsb_first;
    logic              tx_dir;
    logic [RATE_W-1:0] rate;
  } cfg_t;

  // half of the full serial period, in system clocks; unused codes fold onto code 0
  function automatic int unsigned half_period(logic [RATE_W-1:0] code);
    case (code)
      3'd1:    return 60;
      3'd2:    return 12;
      3'd3:    return 8;
      3'd4:    return 6;
      3'd5:    return 5;
      default: return 180;
    endcase
  endfunction
endpackage

// File: rtl/ssp_rate_div.sv
module ssp_rate_div
  import ssp_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [DIV_W-1:0] cnt_q, limit;

  assign limit  = DIV_W'(half_period(rate_i) - 1);
  assign tick_o = run_i && (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (tick_o)      cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  // R3
  rate_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= limit);
endmodule

// File: rtl/ssp_edge_sync.sv
module ssp_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  output logic rise_o,
  output logic fall_o
);
  logic [2:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 3'b111;
    else         sync_q <= {sync_q[1:0], sck_i};
  end

  assign rise_o = sync_q[1] && !sync_q[2];
  assign fall_o = !sync_q[1] && sync_q[2];
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              arm_i,
  input  logic              ev_fall_i,
  input  logic              ev_rise_i,
  input  logic              lsb_first_i,
  input  logic              sin_i,
  output logic              sout_o,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o
);
  logic [DATA_W-1:0] sr_q, sr_shift;
  logic [CNT_W-1:0]  cnt_q;
  logic              out_q;

  assign sr_shift = lsb_first_i ? {sin_i, sr_q[DATA_W-1:1]}
                                : {sr_q[DATA_W-2:0], sin_i};
  assign last_o   = ev_rise_i && (cnt_q == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
      out_q <= 1'b1;
    end else begin
      if (load_i)         sr_q <= load_data_i;
      else if (ev_rise_i) sr_q <= sr_shift;
      if (arm_i)          cnt_q <= '0;
      else if (ev_rise_i) cnt_q <= cnt_q + 1'b1;
      if (ev_fall_i)      out_q <= lsb_first_i ? sr_q[0] : sr_q[DATA_W-1];
    end
  end

  assign sout_o = out_q;
  assign data_o = sr_q;

  // R7
  sr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_rise_i && !load_i |=> $stable(sr_q));
endmodule

// File: rtl/ssp_port.sv
module ssp_port
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_master_i,
  input  logic              cfg_two_wire_i,
  input  logic              cfg_lsb_first_i,
  input  logic              cfg_tx_dir_i,
  input  logic [RATE_W-1:0] cfg_rate_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              start_i,
  input  logic              irq_clr_i,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic              sd_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  output logic              sd_o,
  output logic              sd_oe_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              irq_o
);
  cfg_t cfg_q;
  logic busy_q, irq_q, sck_q;
  logic go, tick, s_rise, s_fall, ev_rise, ev_fall, done;

  assign go = start_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (go) cfg_q <= '{master: cfg_master_i, two_wire: cfg_two_wire_i,
                            lsb_first: cfg_lsb_first_i, tx_dir: cfg_tx_dir_i,
                            rate: cfg_rate_i};
  end

  ssp_rate_div #(.DIV_W(DIV_W)) i_rate_div (
    .clk_i, .rst_ni,
    .run_i  (busy_q && cfg_q.master),
    .rate_i (cfg_q.rate),
    .tick_o (tick)
  );

  ssp_edge_sync i_edge_sync (
    .clk_i, .rst_ni,
    .sck_i,
    .rise_o (s_rise),
    .fall_o (s_fall)
  );

  assign ev_fall = busy_q && (cfg_q.master ? (tick && sck_q)  : s_fall);
  assign ev_rise = busy_q && (cfg_q.master ? (tick && !sck_q) : s_rise);

  ssp_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk_i, .rst_ni,
    .load_i      (wr_en_i && !busy_q),
    .load_data_i (wr_data_i),
    .arm_i       (go),
    .ev_fall_i   (ev_fall),
    .ev_rise_i   (ev_rise),
    .lsb_first_i (cfg_q.lsb_first),
    .sin_i       (cfg_q.two_wire ? sd_i : si_i),
    .sout_o      (sd_o),
    .data_o      (rd_data_o),
    .last_o      (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
      sck_q  <= 1'b1;
    end else begin
      if (go)        busy_q <= 1'b1;
      else if (done) busy_q <= 1'b0;
      if (done)           irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
      if (cfg_q.master && tick) sck_q <= !sck_q;
    end
  end

  assign sck_o    = sck_q;
  assign sck_oe_o = cfg_master_i;
  assign sd_oe_o  = busy_q ? !(cfg_q.two_wire && !cfg_q.tx_dir)
                           : !(cfg_two_wire_i && !cfg_tx_dir_i);
  assign busy_o   = busy_q;
  assign irq_o    = irq_q;

  // R8
  done_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> irq_q);
  // R5
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> sck_q);
  // R7
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(start_i));
  // R6
  rx_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) && $past(cfg_two_wire_i) && !$past(cfg_tx_dir_i) |-> !sd_oe_o);
endmodule

// File: tb/test_ssp_port.sv
module test_ssp_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;

  // channel A (master) and B (slave) controls
  logic a_ms = 1'b1, a_2w = 1'b0, a_lsb = 1'b0, a_dir = 1'b1;
  logic b_ms = 1'b0, b_2w = 1'b0, b_lsb = 1'b0, b_dir = 1'b1;
  logic [2:0] a_rate = 3'd5;
  logic a_wr = 1'b0, b_wr = 1'b0, a_st = 1'b0, b_st = 1'b0, a_clr = 1'b0, b_clr = 1'b0;
  logic [7:0] a_wd = '0, b_wd = '0;

  logic a_sck, a_sck_oe, a_sd, a_sd_oe, a_busy, a_irq;
  logic b_sck, b_sck_oe, b_sd, b_sd_oe, b_busy, b_irq;
  logic [7:0] a_rd, b_rd;
  logic line;

  assign line = a_sd_oe ? a_sd : (b_sd_oe ? b_sd : 1'b1);

  ssp_port i_ssp_port (
    .clk_i(clk), .rst_ni(rst_n), .cfg_master_i(a_ms), .cfg_two_wire_i(a_2w),
    .cfg_lsb_first_i(a_lsb), .cfg_tx_dir_i(a_dir), .cfg_rate_i(a_rate),
    .wr_en_i(a_wr), .wr_data_i(a_wd), .start_i(a_st), .irq_clr_i(a_clr),
    .sck_i(1'b1), .si_i(b_sd), .sd_i(line),
    .sck_o(a_sck), .sck_oe_o(a_sck_oe), .sd_o(a_sd), .sd_oe_o(a_sd_oe),
    .rd_data_o(a_rd), .busy_o(a_busy), .irq_o(a_irq)
  );

  ssp_port i_ssp_port_peer (
    .clk_i(clk), .rst_ni(rst_n), .cfg_master_i(b_ms), .cfg_two_wire_i(b_2w),
    .cfg_lsb_first_i(b_lsb), .cfg_tx_dir_i(b_dir), .cfg_rate_i(3'd0),
    .wr_en_i(b_wr), .wr_data_i(b_wd), .start_i(b_st), .irq_clr_i(b_clr),
    .sck_i(a_sck), .si_i(a_sd), .sd_i(line),
    .sck_o(b_sck), .sck_oe_o(b_sck_oe), .sd_o(b_sd), .sd_oe_o(b_sd_oe),
    .rd_data_o(b_rd), .busy_o(b_busy), .irq_o(b_irq)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  function automatic int ratio(input logic [2:0] c);
    case (c)
      3'd1: return 120; 3'd2: return 24; 3'd3: return 16;
      3'd4: return 12;  3'd5: return 10; default: return 360;
    endcase
  endfunction

  logic mid_oe;

  task automatic xfer(input logic [7:0] da, input logic [7:0] db, input logic mid_wr,
                      output int cyc);
    @(negedge clk); a_wr = 1'b1; a_wd = da; b_wr = 1'b1; b_wd = db;
    @(negedge clk); a_wr = 1'b0; b_wr = 1'b0; b_st = 1'b1;
    @(negedge clk); b_st = 1'b0; a_st = 1'b1;
    @(negedge clk); a_st = 1'b0;
    cyc = 0;
    mid_oe = 1'b1;
    while (a_busy && cyc < 5000) begin
      cyc++;
      a_wr = (mid_wr && cyc == 40);
      a_wd = 8'hFF;
      if (cyc == 30) mid_oe = a_sd_oe;
      @(negedge clk);
    end
    a_wr = 1'b0;
    for (int k = 0; k < 20 && b_busy; k++) @(negedge clk);
  endtask

  initial begin : watchdog
    for (int n = 0; n < 150000; n++) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!a_busy && !a_irq && a_sck, "R10", {a_busy, a_irq, a_sck}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 clock direction and idle level
    chk(a_sck_oe && !b_sck_oe && b_sck, "R5", {a_sck_oe, b_sck_oe, b_sck}, 3'b101);

    // R3/R4 rate sweep, R1 data exchange, R9 slave follows
    for (int c = 0; c < 8; c++) begin
      logic [7:0] da, db;
      da = 8'(8'h35 * c + 8'h1B);
      db = 8'(8'hC3 ^ (c * 8'h2D));
      a_rate = 3'(c);
      xfer(da, db, 1'b0, cyc);
      if (c < 6) chk(cyc == 8 * ratio(3'(c)), "R3 busy length", cyc, 8 * ratio(3'(c)));
      else       chk(cyc == 8 * 360, "R4 reserved code", cyc, 8 * 360);
      chk(b_rd == da, "R9 slave rx", b_rd, da);
      chk(a_rd == db, "R1 master rx", a_rd, db);
      chk(!b_busy, "R9 slave done", b_busy, 0);
      a_clr = 1'b1; b_clr = 1'b1; @(negedge clk); a_clr = 1'b0; b_clr = 1'b0;
    end
    a_rate = 3'd5;

    // R8 irq held then cleared
    xfer(8'h5A, 8'h96, 1'b0, cyc);
    repeat (10) @(negedge clk);
    chk(a_irq && b_irq, "R8 irq held", {a_irq, b_irq}, 2'b11);
    a_clr = 1'b1; @(negedge clk); a_clr = 1'b0;
    chk(!a_irq && b_irq, "R8 irq clear", {a_irq, b_irq}, 2'b01);
    b_clr = 1'b1; @(negedge clk); b_clr = 1'b0;

    // R2 both ends LSB first
    a_lsb = 1'b1; b_lsb = 1'b1;
    xfer(8'hE1, 8'h2C, 1'b0, cyc);
    chk(b_rd == 8'hE1 && a_rd == 8'h2C, "R2 lsb both", {a_rd, b_rd}, 16'h2CE1);
    // R2 mismatched order reverses
    a_lsb = 1'b0; b_lsb = 1'b1;
    xfer(8'hE1, 8'h2C, 1'b0, cyc);
    chk(b_rd == rev8(8'hE1), "R2 reversed at slave", b_rd, rev8(8'hE1));
    chk(a_rd == rev8(8'h2C), "R2 reversed at master", a_rd, rev8(8'h2C));
    b_lsb = 1'b0;

    // R7 write during busy ignored
    xfer(8'h3C, 8'hA5, 1'b1, cyc);
    chk(b_rd == 8'h3C, "R7 tx unaffected", b_rd, 8'h3C);
    chk(a_rd == 8'hA5, "R7 rx unaffected", a_rd, 8'hA5);

    // R6 2-wire, master transmits
    a_2w = 1'b1; b_2w = 1'b1; a_dir = 1'b1; b_dir = 1'b0;
    xfer(8'h71, 8'h0F, 1'b0, cyc);
    chk(mid_oe == 1'b1, "R6 tx drives", mid_oe, 1);
    chk(b_rd == 8'h71, "R6 shared rx at slave", b_rd, 8'h71);
    // R6 2-wire, master receives
    a_dir = 1'b0; b_dir = 1'b1;
    xfer(8'h00, 8'hB4, 1'b0, cyc);
    chk(mid_oe == 1'b0, "R6 rx releases line", mid_oe, 0);
    chk(a_rd == 8'hB4, "R6 shared rx at master", a_rd, 8'hB4);
    // R6 3-wire keeps output enabled regardless of direction bit
    a_2w = 1'b0; b_2w = 1'b0;
    xfer(8'h44, 8'h99, 1'b0, cyc);
    chk(mid_oe == 1'b1, "R6 3-wire enable", mid_oe, 1);
    chk(a_rd == 8'h99, "R1 3-wire after 2-wire", a_rd, 8'h99);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule